// File: doc/BRIEF.md
# Synchronous Divide-by-2/4/8 Clock Generator with Glitch-Free Enable

This block derives three slower clocks from one input clock: one at half, one at a quarter and one at an eighth of its rate. A single binary counter produces all three, and that counter is driven by an internally gated copy of the input clock. Any edge that two outputs share therefore comes from the same counter update.

An active-low common enable starts and stops all three divided clocks together. The enable is registered on the falling edge of the input clock. The gate can therefore only open or close while the input clock is low, and the internal clock never carries a shortened high pulse.

An active-low master reset clears the counter at once and holds every output low. Its release is synchronised to the input clock. Several instances that leave reset on the same input edge then count in phase. The gated internal clock is also brought out so that its pulse shape can be observed.

Top module: `sync_clk_div`

## Requirements
- R1: While `mrst_ni` is low, `div_o` and `gclk_o` are low. After `mrst_ni` rises, the earliest rising edge of `clk_i` at which the count can advance is the third one.
- R2: `div_o` is a binary count that advances by one, modulo 2^DIV_STAGES, on each rising edge of the gated clock. Bit k toggles at 1/2^(k+1) of the gated clock rate: bit 0 is divide-by-2, bit 1 is divide-by-4 and bit 2 is divide-by-8.
- R3: A higher `div_o` bit rises only on the same gated edge on which every lower bit falls. There is no skew between the outputs in cycles of the input clock.
- R4: `en_ni` is active low and is sampled on the falling edge of `clk_i`. When it was low at the last falling edge and the block is out of reset, the next rising edge of `clk_i` produces a rising edge on the gated clock.
- R5: Each high pulse on `gclk_o` lasts exactly one full high phase of `clk_i`, and `gclk_o` is never high while `clk_i` is low.
- R6: While disabled, `div_o` holds its value. After re-enable, counting resumes from the held value, with no count skipped and none repeated.
- R7: The first gated edge after reset release sets bit 0 of `div_o` to 1. All bits are high together on every eighth gated edge (count 7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| mrst_ni | input | 1 | Master reset, active low; asserts asynchronously, releases synchronously |
| en_ni | input | 1 | Common enable, active low, sampled on the falling edge of `clk_i` |
| gclk_o | output | 1 | Gated internal clock that drives the counter |
| div_o | output | DIV_STAGES | Divided clocks; bit k runs at 1/2^(k+1) of the input rate |

## Verification
An enable level in force at a falling edge shows on `gclk_o` and `div_o` during the next high phase of `clk_i`. A reset release takes effect on the third rising edge. The bench keeps a model that updates at each rising edge and captures the enable at mid-cycle, a point where the enable input is stable across the falling edge. It compares outputs 5 ns after each rising edge and again 5 ns after each falling edge. All inputs change only 2 ns after an edge, so no sample coincides with an edge. Pulse width is measured directly between the edges of `gclk_o`.

// File: rtl/sync_clk_div_pkg.sv
package sync_clk_div_pkg;
  // Number of binary divider stages (divide by 2, 4, 8 ...).
  localparam int unsigned DIV_STAGES_DEF = 3;
  // Depth of the reset release synchroniser (must be at least 2).
  localparam int unsigned RST_SYNC_DEF   = 2;
endpackage

// File: rtl/sync_clk_div_rst.sv
module sync_clk_div_rst #(
  parameter int unsigned STAGES = sync_clk_div_pkg::RST_SYNC_DEF
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[TOP-1:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) shift_q <= '0;
    else          shift_q <= shift_d;
  end

  assign rst_no = shift_q[TOP];
endmodule

// File: rtl/sync_clk_div_gate.sv
module sync_clk_div_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  output logic en_q_o,
  output logic gclk_o
);
  logic en_q;
  logic en_d;

  always_comb begin
    en_d = ~en_ni;
  end

  // Captured while the clock falls, so the gate changes only in the low phase.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign en_q_o = en_q;
  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/sync_clk_div_cnt.sv
module sync_clk_div_cnt #(
  parameter int unsigned STAGES = sync_clk_div_pkg::DIV_STAGES_DEF
) (
  input  logic              gclk_i,
  input  logic              rst_ni,
  output logic [STAGES-1:0] div_o
);
  localparam logic [STAGES-1:0] CNT_ONE = STAGES'(1);

  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge gclk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign div_o = cnt_q;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_align
      // R3
      edge_align_chk: assert property (@(posedge gclk_i) disable iff (!rst_ni)
        $rose(cnt_q[i]) |-> $fell(cnt_q[i-1]));
    end
  endgenerate
endmodule

// File: rtl/sync_clk_div.sv
module sync_clk_div #(
  parameter int unsigned DIV_STAGES = sync_clk_div_pkg::DIV_STAGES_DEF,
  parameter int unsigned RST_SYNC   = sync_clk_div_pkg::RST_SYNC_DEF
) (
  input  logic                  clk_i,
  input  logic                  mrst_ni,
  input  logic                  en_ni,
  output logic                  gclk_o,
  output logic [DIV_STAGES-1:0] div_o
);
  logic rst_n_s;
  logic en_q;
  logic gclk;

  sync_clk_div_rst #(.STAGES(RST_SYNC)) u_rst (
    .clk_i  (clk_i),
    .arst_ni(mrst_ni),
    .rst_no (rst_n_s)
  );

  sync_clk_div_gate u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .en_ni (en_ni),
    .en_q_o(en_q),
    .gclk_o(gclk)
  );

  sync_clk_div_cnt #(.STAGES(DIV_STAGES)) u_cnt (
    .gclk_i(gclk),
    .rst_ni(rst_n_s),
    .div_o (div_o)
  );

  assign gclk_o = gclk;

  // R6
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !en_q |=> $stable(div_o));

  // R2
  step_when_on_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    en_q |=> (div_o == DIV_STAGES'($past(div_o) + 1'b1)));

  // R1
  reset_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (div_o == '0));

  // R5
  gate_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !gclk);
endmodule

// File: tb/tb_sync_clk_div.sv
`timescale 1ns/1ps
module tb_sync_clk_div;
  logic       clk = 1'b0;
  logic       mrst_ni = 1'b0;
  logic       en_ni = 1'b1;
  logic       gclk_o;
  logic [2:0] div_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  logic [2:0] m_cnt = '0;
  logic       m_en = 1'b0;
  logic       m_s1 = 1'b0;
  logic       m_rstn = 1'b0;
  logic       bumped = 1'b0;
  logic       first_after_rst = 1'b0;
  logic [2:0] prev_cnt = '0;
  realtime    t_rise = 0.0;

  sync_clk_div dut (
    .clk_i  (clk),
    .mrst_ni(mrst_ni),
    .en_ni  (en_ni),
    .gclk_o (gclk_o),
    .div_o  (div_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string pick_tag(input logic [2:0] c, input logic [2:0] p,
                                     input logic b, input logic f);
    if (!mrst_ni || !m_rstn) return "R1";
    if (b && f)              return "R7";
    if (b && c == 3'd7)      return "R7";
    if (!b)                  return "R6";
    if (c[1:0] == 2'b00)     return "R3";
    return "R2";
  endfunction

  // R5: width of every gated high pulse
  always @(posedge gclk_o) t_rise = $realtime;
  always @(negedge gclk_o) begin
    if (!done) chk(($realtime - t_rise) == 10.0, "R5 pulse width",
                   int'($realtime - t_rise), 10);
  end

  task automatic cyc(input logic ea, input logic eb, input logic mb);
    @(posedge clk);
    prev_cnt = m_cnt;
    if (!mrst_ni) begin
      m_cnt = '0; m_en = 1'b0; m_s1 = 1'b0; m_rstn = 1'b0; bumped = 1'b0;
    end else begin
      bumped = m_rstn && m_en;
      if (bumped) m_cnt = m_cnt + 3'd1;
      m_rstn = m_s1;
      m_s1 = 1'b1;
    end
    #2 en_ni = ea;
    #3;
    chk(div_o == m_cnt, pick_tag(m_cnt, prev_cnt, bumped, first_after_rst),
        int'(div_o), int'(m_cnt));
    chk(gclk_o == bumped, "R4 gate", int'(gclk_o), int'(bumped));
    if (bumped) first_after_rst = 1'b0;
    #2 m_en = m_rstn ? ~en_ni : 1'b0;
    #5 en_ni = eb;
    if (mrst_ni && !mb) first_after_rst = 1'b1;
    mrst_ni = mb;
    if (!mb) begin
      m_cnt = '0; m_en = 1'b0; m_s1 = 1'b0; m_rstn = 1'b0;
    end
    #3;
    chk(gclk_o == 1'b0, "R5 low phase", int'(gclk_o), 0);
    chk(div_o == m_cnt, mrst_ni ? "R2 hold" : "R1", int'(div_o), int'(m_cnt));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    first_after_rst = 1'b1;
    // R1: reset state, enable already asserted
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0);
    // R1 / R7: release and count from the third edge
    cyc(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 1'b1);
    // R6: freeze, then resume
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 1'b1);
    // R4: enable changed after the falling edge only
    for (int i = 0; i < 6; i++) cyc(1'b0, i[0], 1'b1);
    // R1: reset in mid count
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b1);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic ea;
      logic eb;
      logic mb;
      ea = ($urandom % 4 == 0) ? ~en_ni : en_ni;
      eb = ($urandom % 4 == 0) ? ~ea : ea;
      mb = ($urandom % 250 == 0) ? 1'b0 : 1'b1;
      cyc(ea, eb, mb);
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(64'd3_000_000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule